// File: doc/BRIEF.md
# Descriptor Ring Controller

This block runs two rings of buffer descriptors, one for transmit and one for receive, stored in one on-chip descriptor RAM. A descriptor uses two 32-bit words. Software fills in descriptors through a host port on the RAM, sets a ready flag and enables a ring. The controller then fetches each ready descriptor in turn. It offers the buffer pointer, the frame length and the byte enables for the first buffer access to a data engine through a valid/ready handshake. When the engine signals completion with a status byte, the controller writes the control word back with the ready flag cleared. It raises a one-cycle interrupt if the descriptor asked for one.

The transmit ring starts at word 0. The receive ring starts right after a programmable number of transmit descriptors. Each ring wraps on a per-descriptor wrap flag, not at a fixed size. Both rings share one RAM port, and a round-robin arbiter shares it between them. A descriptor that is not ready holds its ring. The ring reads that descriptor again until software marks it ready.

Top module: `dring_ctl`

## Requirements
- R1: Descriptor k of a ring occupies word base+2k (control word) and word base+2k+1 (buffer pointer). In the control word, bits 31:16 hold the length, bit 15 is ready, bit 14 requests an interrupt and bit 13 is wrap. A fetched ready descriptor is offered with its pointer on `*_ptr` and its length on `*_len`.
- R2: For a transmit descriptor, bit 9 of the control word appears on `tx_ctrl_frame` with the offer.
- R3: The transmit ring base is word 0. Receive descriptor i sits at word 2*(tx_desc_count + i).
- R4: After a descriptor whose wrap bit is 1 completes, the ring index returns to 0. Otherwise the index advances by one.
- R5: A descriptor whose ready bit is 0 is never offered. The ring stays on it and re-reads it until the bit is set.
- R6: On completion, the control word is rewritten as: length unchanged, bit 15 = 0, bits 14:8 unchanged, bits 7:0 = the engine's status byte.
- R7: A completion pulses `*_irq` high for exactly one cycle if bit 14 was set, and never otherwise.
- R8: `*_first_be` follows pointer bits 1:0 as 0→1111, 1→0111, 2→0011, 3→0001.
- R9: An offer holds valid, pointer and length stable until ready is seen. Valid is low in the cycle after the handshake.
- R10: The RAM port is granted to at most one ring per cycle. When both rings request together they alternate, so both make progress.
- R11: After reset, valid and irq outputs are low. A disabled ring offers nothing.
- R12: A host read returns the addressed word on `host_rdata` one cycle after the request. A host write stores the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit ring enable |
| rx_en | input | 1 | Receive ring enable |
| tx_desc_count | input | 8 | Number of transmit descriptors (receive ring offset) |
| host_en | input | 1 | Host RAM access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after request |
| tx_valid | output | 1 | Transmit offer valid |
| tx_ready | input | 1 | Transmit engine accepts offer |
| tx_ptr | output | 32 | Transmit buffer pointer |
| tx_len | output | 16 | Transmit frame length |
| tx_ctrl_frame | output | 1 | Transmit descriptor marks a control frame |
| tx_first_be | output | 4 | Byte enables for first transmit buffer access |
| tx_done | input | 1 | Transmit engine completion pulse |
| tx_status | input | 8 | Transmit completion status |
| tx_irq | output | 1 | Transmit completion interrupt pulse |
| rx_valid | output | 1 | Receive offer valid |
| rx_ready | input | 1 | Receive engine accepts offer |
| rx_ptr | output | 32 | Receive buffer pointer |
| rx_len | output | 16 | Receive length field |
| rx_first_be | output | 4 | Byte enables for first receive buffer access |
| rx_done | input | 1 | Receive engine completion pulse |
| rx_status | input | 8 | Receive completion status |
| rx_irq | output | 1 | Receive completion interrupt pulse |

## Verification
The two rings' descriptor fetches can ask for the single RAM port in the same cycle. The bench causes this by loading a ready descriptor in each ring and raising both enables on the same clock edge. It judges the result by checking that both offers arrive with the correct pointers and byte enables, and that the receive offer stays stable while the transmit one is served. A grant check in the checker confirms that the port never goes to both rings at once.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W   = 32;
  localparam int STAT_W   = 8;
  localparam int LEN_W    = 16;
  localparam int BIT_RDY  = 15;
  localparam int BIT_IRQ  = 14;
  localparam int BIT_WRAP = 13;
  localparam int BIT_CTLF = 9;
  localparam int KEEP_LO  = 8;
  localparam int KEEP_W   = BIT_IRQ - KEEP_LO + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTL, ST_CK_CTL, ST_RD_PTR, ST_CK_PTR, ST_OFFER, ST_BUSY, ST_WBACK
  } chan_st_e;
endpackage

// File: rtl/dring_ram.sv
module dring_ram #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DW-1:0]     a_wdata,
  output logic [DW-1:0]     a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DW-1:0]     b_wdata,
  output logic [DW-1:0]     b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wdata;
    if (b_en && b_we) mem[b_addr] <= b_wdata;
    if (a_en && !a_we) a_rdata <= mem[a_addr];
    if (b_en && !b_we) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/dring_arb.sv
module dring_arb #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        req,
  input  logic [1:0]        we,
  input  logic [ADDR_W-1:0] addr0,
  input  logic [ADDR_W-1:0] addr1,
  input  logic [DW-1:0]     wdata0,
  input  logic [DW-1:0]     wdata1,
  output logic [1:0]        gnt,
  output logic              p_en,
  output logic              p_we,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DW-1:0]     p_wdata
);
  logic last_one;

  always_comb begin
    gnt[0]  = req[0] && (!req[1] || last_one);
    gnt[1]  = req[1] && (!req[0] || !last_one);
    p_en    = |gnt;
    p_we    = gnt[1] ? we[1]  : (gnt[0] && we[0]);
    p_addr  = gnt[1] ? addr1  : addr0;
    p_wdata = gnt[1] ? wdata1 : wdata0;
  end

  always_ff @(posedge clk) begin
    if (rst) last_one <= 1'b1;
    else if (|gnt) last_one <= gnt[1];
  end
endmodule

// File: rtl/dring_chan.sv
module dring_chan
  import dring_pkg::*;
#(
  parameter bit IS_TX  = 1'b1,
  parameter int IDX_W  = 7,
  parameter int ADDR_W = IDX_W + 1,
  parameter int INFO_W = 53
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [ADDR_W-1:0]   base,
  output logic                req,
  output logic                we,
  output logic [ADDR_W-1:0]   addr,
  output logic [WORD_W-1:0]   wdata,
  input  logic                gnt,
  input  logic [WORD_W-1:0]   rdata,
  output logic                valid,
  input  logic                ready,
  output logic [INFO_W-1:0]   info,
  input  logic                done,
  input  logic [STAT_W-1:0]   status,
  output logic                irq
);
  chan_st_e            st;
  logic [IDX_W-1:0]    idx;
  logic [LEN_W-1:0]    len_q;
  logic [KEEP_W-1:0]   keep_q;
  logic [STAT_W-1:0]   stat_q;
  logic [3:0]          be_d;
  logic [INFO_W-1:0]   info_d;

  assign be_d = 4'b1111 >> rdata[1:0];

  generate
    if (IS_TX) begin : g_tx_info
      assign info_d = {keep_q[BIT_CTLF-KEEP_LO], be_d, len_q, rdata};
    end else begin : g_rx_info
      assign info_d = {be_d, len_q, rdata};
    end
  endgenerate

  always_comb begin
    req   = (st == ST_RD_CTL) || (st == ST_RD_PTR) || (st == ST_WBACK);
    we    = (st == ST_WBACK);
    addr  = ADDR_W'(base + {idx, 1'b0} + ADDR_W'(st == ST_RD_PTR));
    wdata = {len_q, 1'b0, keep_q, stat_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      idx    <= '0;
      len_q  <= '0;
      keep_q <= '0;
      stat_q <= '0;
      info   <= '0;
      valid  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (st)
        ST_IDLE:   if (en) st <= ST_RD_CTL;
        ST_RD_CTL: if (gnt) st <= ST_CK_CTL;
        ST_CK_CTL: begin
          len_q  <= rdata[WORD_W-1 -: LEN_W];
          keep_q <= rdata[BIT_IRQ:KEEP_LO];
          st     <= rdata[BIT_RDY] ? ST_RD_PTR : ST_IDLE;
        end
        ST_RD_PTR: if (gnt) st <= ST_CK_PTR;
        ST_CK_PTR: begin
          info  <= info_d;
          valid <= 1'b1;
          st    <= ST_OFFER;
        end
        ST_OFFER: if (ready) begin
          valid <= 1'b0;
          st    <= ST_BUSY;
        end
        ST_BUSY: if (done) begin
          stat_q <= status;
          st     <= ST_WBACK;
        end
        ST_WBACK: if (gnt) begin
          irq <= keep_q[BIT_IRQ-KEEP_LO];
          idx <= keep_q[BIT_WRAP-KEEP_LO] ? '0 : idx + 1'b1;
          st  <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dring_ctl.sv
module dring_ctl
  import dring_pkg::*;
#(
  parameter int NUM_DESC = 128,
  parameter int IDX_W    = $clog2(NUM_DESC),
  parameter int ADDR_W   = IDX_W + 1,
  parameter int CNT_W    = $clog2(NUM_DESC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [CNT_W-1:0]  tx_desc_count,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_ptr,
  output logic [15:0]       tx_len,
  output logic              tx_ctrl_frame,
  output logic [3:0]        tx_first_be,
  input  logic              tx_done,
  input  logic [7:0]        tx_status,
  output logic              tx_irq,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [31:0]       rx_ptr,
  output logic [15:0]       rx_len,
  output logic [3:0]        rx_first_be,
  input  logic              rx_done,
  input  logic [7:0]        rx_status,
  output logic              rx_irq
);
  localparam int RX_INFO_W = WORD_W + LEN_W + 4;
  localparam int TX_INFO_W = RX_INFO_W + 1;

  logic [1:0]          arb_req, arb_we, arb_gnt;
  logic [ADDR_W-1:0]   tx_addr, rx_addr, p_addr, rx_base;
  logic [WORD_W-1:0]   tx_wdata, rx_wdata, p_wdata, p_rdata;
  logic                p_en, p_we;
  logic [TX_INFO_W-1:0] tx_info;
  logic [RX_INFO_W-1:0] rx_info;

  assign rx_base = ADDR_W'({tx_desc_count, 1'b0});

  dring_ram #(.ADDR_W(ADDR_W), .DW(WORD_W)) u_ram (
    .clk(clk),
    .a_en(host_en), .a_we(host_we), .a_addr(host_addr),
    .a_wdata(host_wdata), .a_rdata(host_rdata),
    .b_en(p_en), .b_we(p_we), .b_addr(p_addr),
    .b_wdata(p_wdata), .b_rdata(p_rdata)
  );

  dring_arb #(.ADDR_W(ADDR_W), .DW(WORD_W)) u_arb (
    .clk(clk), .rst(rst), .req(arb_req), .we(arb_we),
    .addr0(tx_addr), .addr1(rx_addr), .wdata0(tx_wdata), .wdata1(rx_wdata),
    .gnt(arb_gnt), .p_en(p_en), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata)
  );

  dring_chan #(.IS_TX(1'b1), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .INFO_W(TX_INFO_W)) u_tx (
    .clk(clk), .rst(rst), .en(tx_en), .base('0),
    .req(arb_req[0]), .we(arb_we[0]), .addr(tx_addr), .wdata(tx_wdata),
    .gnt(arb_gnt[0]), .rdata(p_rdata),
    .valid(tx_valid), .ready(tx_ready), .info(tx_info),
    .done(tx_done), .status(tx_status), .irq(tx_irq)
  );

  dring_chan #(.IS_TX(1'b0), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .INFO_W(RX_INFO_W)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .base(rx_base),
    .req(arb_req[1]), .we(arb_we[1]), .addr(rx_addr), .wdata(rx_wdata),
    .gnt(arb_gnt[1]), .rdata(p_rdata),
    .valid(rx_valid), .ready(rx_ready), .info(rx_info),
    .done(rx_done), .status(rx_status), .irq(rx_irq)
  );

  assign {tx_ctrl_frame, tx_first_be, tx_len, tx_ptr} = tx_info;
  assign {rx_first_be, rx_len, rx_ptr} = rx_info;
endmodule

// File: rtl/dring_ctl_chk.sv
module dring_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  gnt,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_ptr,
  input logic [15:0] tx_len,
  input logic [3:0]  tx_first_be,
  input logic        tx_irq,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_ptr,
  input logic [15:0] rx_len,
  input logic [3:0]  rx_first_be,
  input logic        rx_irq
);
  assert_one_grant_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_ptr) && $stable(tx_len)));
  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_ptr) && $stable(rx_len)));

  assert_tx_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_valid);
  assert_rx_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready) |=> !rx_valid);

  assert_tx_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);
  assert_rx_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  assert_tx_be_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_first_be[0] && ($countones(tx_first_be) == 4 - int'(tx_ptr[1:0]))));
  assert_rx_be_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_first_be[0] && ($countones(rx_first_be) == 4 - int'(rx_ptr[1:0]))));
endmodule

bind dring_ctl dring_ctl_chk u_chk (
  .clk(clk), .rst(rst), .gnt(arb_gnt),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ptr(tx_ptr), .tx_len(tx_len),
  .tx_first_be(tx_first_be), .tx_irq(tx_irq),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ptr(rx_ptr), .rx_len(rx_len),
  .rx_first_be(rx_first_be), .rx_irq(rx_irq)
);

// File: tb/dring_ctl_bench.sv
`timescale 1ns/1ps
module dring_ctl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 0, rx_en = 0;
  logic [7:0] tx_desc_count = 8'd4;
  logic host_en = 0, host_we = 0;
  logic [7:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic tx_valid, tx_ready = 0, tx_ctrl_frame, tx_done = 0, tx_irq;
  logic [31:0] tx_ptr; logic [15:0] tx_len; logic [3:0] tx_first_be;
  logic [7:0] tx_status = '0;
  logic rx_valid, rx_ready = 0, rx_done = 0, rx_irq;
  logic [31:0] rx_ptr; logic [15:0] rx_len; logic [3:0] rx_first_be;
  logic [7:0] rx_status = '0;

  int n_tests = 0, n_fail = 0;
  int tx_irq_cnt = 0, rx_irq_cnt = 0;

  always #5 clk = ~clk;

  dring_ctl u_dring_ctl (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .tx_desc_count(tx_desc_count),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ptr(tx_ptr), .tx_len(tx_len),
    .tx_ctrl_frame(tx_ctrl_frame), .tx_first_be(tx_first_be), .tx_done(tx_done),
    .tx_status(tx_status), .tx_irq(tx_irq),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ptr(rx_ptr), .rx_len(rx_len),
    .rx_first_be(rx_first_be), .rx_done(rx_done), .rx_status(rx_status), .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    if (tx_irq) tx_irq_cnt <= tx_irq_cnt + 1;
    if (rx_irq) rx_irq_cnt <= rx_irq_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_en = 0; host_we = 0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); host_en = 1; host_we = 0; host_addr = a;
    @(negedge clk); host_en = 0; d = host_rdata;
  endtask

  task automatic wait_tx(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_valid) begin ok = 1; break; end
    end
  endtask

  task automatic wait_rx(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rx_valid) begin ok = 1; break; end
    end
  endtask

  task automatic tx_finish(input logic [7:0] st);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    check("R9 tx valid drops after handshake", {31'd0, tx_valid}, 32'd0);
    repeat (3) @(negedge clk);
    tx_status = st; tx_done = 1; @(negedge clk); tx_done = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic rx_finish(input logic [7:0] st);
    rx_ready = 1; @(negedge clk); rx_ready = 0;
    check("R9 rx valid drops after handshake", {31'd0, rx_valid}, 32'd0);
    repeat (2) @(negedge clk);
    rx_status = st; rx_done = 1; @(negedge clk); rx_done = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
    check("R11 rx_valid after reset", {31'd0, rx_valid}, 32'd0);
    check("R11 irq after reset", {30'd0, tx_irq, rx_irq}, 32'd0);
  endtask

  task automatic t_host;
    logic [31:0] d;
    for (int a = 0; a < 20; a++) hwr(8'(a), 32'h0);
    hwr(8'd30, 32'hCAFE_F00D);
    hrd(8'd30, d);
    check("R12 host write/read", d, 32'hCAFE_F00D);
  endtask

  task automatic t_both_rings;
    bit ok; logic [31:0] d;
    hwr(8'd1, 32'h1000_0002);
    hwr(8'd0, 32'h0040_C200);
    hwr(8'd9, 32'h3000_0001);
    hwr(8'd8, 32'h05EE_E000);
    repeat (30) @(negedge clk);
    check("R11 disabled ring offers nothing", {30'd0, tx_valid, rx_valid}, 32'd0);
    tx_en = 1; rx_en = 1;
    wait_tx(ok);
    check("R10 tx offer under contention", {31'd0, ok}, 32'd1);
    check("R1 tx pointer", tx_ptr, 32'h1000_0002);
    check("R1 tx length", {16'd0, tx_len}, 32'h0040);
    check("R2 tx control-frame bit", {31'd0, tx_ctrl_frame}, 32'd1);
    check("R8 be for offset 2", {28'd0, tx_first_be}, 32'h3);
    repeat (5) @(negedge clk);
    check("R9 tx offer held", tx_ptr, 32'h1000_0002);
    tx_irq_cnt = 0;
    tx_finish(8'hA5);
    check("R7 tx irq one pulse", 32'(tx_irq_cnt), 32'd1);
    hrd(8'd0, d);
    check("R6 tx write-back word", d, 32'h0040_42A5);
    check("R10 rx offer under contention", {31'd0, rx_valid}, 32'd1);
    check("R3 rx pointer from word 9", rx_ptr, 32'h3000_0001);
    check("R1 rx length", {16'd0, rx_len}, 32'h05EE);
    check("R8 be for offset 1", {28'd0, rx_first_be}, 32'h7);
    rx_irq_cnt = 0;
    rx_finish(8'h3C);
    check("R7 rx irq one pulse", 32'(rx_irq_cnt), 32'd1);
    hrd(8'd8, d);
    check("R6 rx write-back word", d, 32'h05EE_603C);
  endtask

  task automatic t_stall_wrap;
    bit ok; logic [31:0] d;
    repeat (40) @(negedge clk);
    check("R5 not-ready descriptor not offered", {31'd0, tx_valid}, 32'd0);
    hwr(8'd5, 32'h5555_0000);
    hwr(8'd4, 32'h0020_8000);
    hwr(8'd3, 32'h2000_0003);
    hwr(8'd2, 32'h0010_A000);
    wait_tx(ok);
    check("R5 offer after ready set", {31'd0, ok}, 32'd1);
    check("R4 index advanced to 1", tx_ptr, 32'h2000_0003);
    check("R2 control-frame clear", {31'd0, tx_ctrl_frame}, 32'd0);
    check("R8 be for offset 3", {28'd0, tx_first_be}, 32'h1);
    tx_irq_cnt = 0;
    tx_finish(8'h11);
    check("R7 no irq without request", 32'(tx_irq_cnt), 32'd0);
    hrd(8'd2, d);
    check("R6 write-back keeps wrap", d, 32'h0010_2011);
    hwr(8'd1, 32'h4000_0000);
    hwr(8'd0, 32'h0008_8000);
    wait_tx(ok);
    check("R4 wrap returns to descriptor 0", tx_ptr, 32'h4000_0000);
    check("R8 be for offset 0", {28'd0, tx_first_be}, 32'hF);
    tx_finish(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_host;
    t_both_rings;
    t_stall_wrap;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule